// File: doc/BRIEF.md
# Dual-Stage Shift and Latch Register

This block is a serial-to-parallel converter with two independent stages. A shift stage takes one serial bit for each rising edge of a shift strobe, and a holding stage copies the whole shift stage on each rising edge of a separate latch strobe. The parallel outputs always show the holding stage. The shift stage can therefore be refilled without disturbing what the outputs present. The last shift-stage bit is brought out as a cascade output, so several instances can be chained into one longer serial path.

Both strobes are external, slow signals. Each one passes through a synchronizer and a rising-edge detector clocked by the system clock, and each qualifying edge becomes a one-cycle enable. An active-low clear empties the shift stage at once and leaves the holding stage alone. Its release is synchronized to the system clock.

The parallel outputs can be put into a high-impedance state. This is modelled as a data vector plus a per-bit drive-enable vector. The cascade output is always driven.

Top module: `shift_hold_reg`

## Requirements
- R1: A rising edge on `shift_stb` shifts the shift stage by one place. `ser_in` enters bit 0, and every bit moves from index i to index i+1. The new contents are visible no later than four system clock cycles after the strobe goes high.
- R2: A rising edge on `latch_stb` copies all shift-stage bits into the holding stage, which is seen on `par_data`. Without such an edge, `par_data` keeps its value.
- R3: While `clr_n` is low, the shift stage is all zeros and shift strobes have no effect. The holding stage (`par_data`) is not changed by the clear. After `clr_n` returns high, shifting resumes.
- R4: When `oe_n` is high, every bit of `par_oe` is 0, which marks the outputs as high impedance. When `oe_n` is low, every bit of `par_oe` is 1 and `par_data` carries the holding stage.
- R5: `cascade_out` always equals the highest shift-stage bit, whatever the level of `oe_n`. When it is fed into the `ser_in` of a second instance whose strobes are tied to the same signals, the second instance receives the overflow bits in order.
- R6: If a shift edge and a latch edge arrive together, the holding stage captures the shift-stage contents from before that shift. The holding stage then trails the shift stage by one shift.
- R7: With no rising edge on `shift_stb`, the shift stage does not change, however `ser_in` toggles. A strobe held high for many cycles causes exactly one shift.
- R8: While `rst_n` is low, both stages are cleared, so `par_data` is 0 and `cascade_out` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples all strobes |
| rst_n | input | 1 | Active-low system reset for both stages and the synchronizers |
| ser_in | input | 1 | Serial data bit taken on a shift edge |
| shift_stb | input | 1 | External shift strobe; its rising edge shifts |
| clr_n | input | 1 | Active-low clear of the shift stage only |
| latch_stb | input | 1 | External latch strobe; its rising edge copies into the holding stage |
| oe_n | input | 1 | Active-low output enable for the parallel outputs |
| par_data | output | WIDTH | Holding-stage contents |
| par_oe | output | WIDTH | Per-bit drive enable; 0 marks high impedance |
| cascade_out | output | 1 | Highest shift-stage bit, always driven |

## Verification
The bench targets four corner cases:
- Tied strobes. A design that latched after the shift would show the new byte one pulse too early.
- A clear with a shift strobe during it. A design that let the clear reach the holding stage, or let the shift through, would change `par_data` or `cascade_out`.
- A long-held strobe and a toggling serial input with no strobe. Level-sensitive shifting or a missing edge detector would corrupt the contents.
- The disabled output state. A design that gated the cascade with the enable would break the chained second instance, whose received bytes are compared in order against a bench model.

// File: rtl/shl_pkg.sv
package shl_pkg;
   localparam int unsigned SHL_DEF_WIDTH = 8;
   localparam int unsigned SHL_DEF_SYNC  = 2;

   typedef struct packed {
      logic shift;
      logic latch;
   } shl_pulse_t;
endpackage

// File: rtl/shl_strobe_sync.sv
module shl_strobe_sync #(
   parameter int unsigned STAGES = shl_pkg::SHL_DEF_SYNC
) (
   input  logic clk,
   input  logic rst_n,
   input  logic strobe_in,
   output logic pulse_o
);
   localparam int unsigned LAST = STAGES - 1;

   initial begin
      assert (STAGES >= 2) else $error("shl_strobe_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain_q;
   logic              prev_q;

   for (genvar i = 0; i < STAGES; i++) begin : g_sync
      if (i == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q[i] <= 1'b0;
            else        chain_q[i] <= strobe_in;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q[i] <= 1'b0;
            else        chain_q[i] <= chain_q[i-1];
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= 1'b0;
      else        prev_q <= chain_q[LAST];
   end

   assign pulse_o = chain_q[LAST] & ~prev_q;

   // R7
   single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pulse_o |=> !pulse_o);
endmodule

// File: rtl/shl_clear_release.sv
module shl_clear_release #(
   parameter int unsigned STAGES = shl_pkg::SHL_DEF_SYNC
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr_n,
   output logic run_n
);
   localparam int unsigned LAST = STAGES - 1;

   logic              src_n;
   logic [STAGES-1:0] rel_q;

   assign src_n = clr_n & rst_n;

   for (genvar i = 0; i < STAGES; i++) begin : g_rel
      always_ff @(posedge clk or negedge src_n) begin
         if (!src_n) rel_q[i] <= 1'b0;
         else        rel_q[i] <= (i == 0) ? 1'b1 : rel_q[(i == 0) ? 0 : i-1];
      end
   end

   assign run_n = rel_q[LAST];
endmodule

// File: rtl/shl_shift_stage.sv
module shl_shift_stage #(
   parameter int unsigned WIDTH = shl_pkg::SHL_DEF_WIDTH
) (
   input  logic             clk,
   input  logic             run_n,
   input  logic             shift_en,
   input  logic             ser_in,
   output logic [WIDTH-1:0] q
);
   initial begin
      assert (WIDTH >= 2) else $error("shl_shift_stage: WIDTH must be at least 2");
   end

   always_ff @(posedge clk or negedge run_n) begin
      if (!run_n)        q <= '0;
      else if (shift_en) q <= {q[WIDTH-2:0], ser_in};
   end

   // R1
   shift_move_chk: assert property (@(posedge clk) disable iff (!run_n)
      shift_en |=> q == {$past(q[WIDTH-2:0]), $past(ser_in)});
   // R7
   shift_idle_chk: assert property (@(posedge clk) disable iff (!run_n)
      !shift_en |=> $stable(q));
endmodule

// File: rtl/shl_hold_stage.sv
module shl_hold_stage #(
   parameter int unsigned WIDTH = shl_pkg::SHL_DEF_WIDTH
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             latch_en,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        q <= '0;
      else if (latch_en) q <= d;
   end

   // R2
   hold_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !latch_en |=> $stable(q));
   // R6
   hold_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
      latch_en |=> q == $past(d));
endmodule

// File: rtl/shift_hold_reg.sv
module shift_hold_reg #(
   parameter int unsigned WIDTH       = shl_pkg::SHL_DEF_WIDTH,
   parameter int unsigned SYNC_STAGES = shl_pkg::SHL_DEF_SYNC
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ser_in,
   input  logic             shift_stb,
   input  logic             clr_n,
   input  logic             latch_stb,
   input  logic             oe_n,
   output logic [WIDTH-1:0] par_data,
   output logic [WIDTH-1:0] par_oe,
   output logic             cascade_out
);
   import shl_pkg::*;

   localparam int unsigned MSB = WIDTH - 1;

   shl_pulse_t       pulse;
   logic             run_n;
   logic [WIDTH-1:0] shift_q;
   logic [WIDTH-1:0] hold_q;

   shl_strobe_sync #(.STAGES(SYNC_STAGES)) u_shift_sync (
      .clk(clk), .rst_n(rst_n), .strobe_in(shift_stb), .pulse_o(pulse.shift));

   shl_strobe_sync #(.STAGES(SYNC_STAGES)) u_latch_sync (
      .clk(clk), .rst_n(rst_n), .strobe_in(latch_stb), .pulse_o(pulse.latch));

   shl_clear_release #(.STAGES(SYNC_STAGES)) u_clear (
      .clk(clk), .rst_n(rst_n), .clr_n(clr_n), .run_n(run_n));

   shl_shift_stage #(.WIDTH(WIDTH)) u_shift (
      .clk(clk), .run_n(run_n), .shift_en(pulse.shift), .ser_in(ser_in), .q(shift_q));

   shl_hold_stage #(.WIDTH(WIDTH)) u_hold (
      .clk(clk), .rst_n(rst_n), .latch_en(pulse.latch), .d(shift_q), .q(hold_q));

   assign par_data    = hold_q;
   assign par_oe      = {WIDTH{~oe_n}};
   assign cascade_out = shift_q[MSB];

   // R3
   clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !clr_n |-> (shift_q == '0));
   // R3
   clear_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr_n && !pulse.latch) |=> $stable(par_data));
   // R4
   drive_uniform_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (par_oe == '0) || (par_oe == '1));
   // R8
   reset_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (par_data == '0 && !cascade_out));
endmodule

// File: tb/test_shift_hold_reg.sv
module test_shift_hold_reg;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       ser_in = 1'b0;
   logic       shift_stb = 1'b0;
   logic       clr_n = 1'b1;
   logic       latch_stb = 1'b0;
   logic       oe_n = 1'b0;
   logic [7:0] pd1, po1, pd2, po2;
   logic       cas1, cas2;

   int unsigned n_checks = 0;
   int unsigned n_errors = 0;
   logic        done = 1'b0;

   logic [7:0] m1 = '0, m2 = '0, h1 = '0, h2 = '0;

   localparam logic [7:0] VEC [8] = '{8'hA5, 8'h3C, 8'hFF, 8'h00,
                                      8'h81, 8'h5A, 8'h7E, 8'h96};

   always #5 clk = ~clk;

   shift_hold_reg i_shift_hold_reg (
      .clk(clk), .rst_n(rst_n), .ser_in(ser_in), .shift_stb(shift_stb),
      .clr_n(clr_n), .latch_stb(latch_stb), .oe_n(oe_n),
      .par_data(pd1), .par_oe(po1), .cascade_out(cas1));

   shift_hold_reg i_shift_hold_reg_b (
      .clk(clk), .rst_n(rst_n), .ser_in(cas1), .shift_stb(shift_stb),
      .clr_n(1'b1), .latch_stb(latch_stb), .oe_n(oe_n),
      .par_data(pd2), .par_oe(po2), .cascade_out(cas2));

   task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic strobe(input logic do_shift, input logic do_latch, input logic b);
      ser_in    = b;
      shift_stb = do_shift;
      latch_stb = do_latch;
      repeat (4) @(negedge clk);
      shift_stb = 1'b0;
      latch_stb = 1'b0;
      repeat (4) @(negedge clk);
      if (do_latch) begin
         h1 = m1;
         h2 = m2;
      end
      if (do_shift) begin
         m2 = {m2[6:0], m1[7]};
         if (clr_n) m1 = {m1[6:0], b};
      end
   endtask

   task automatic load_byte(input logic [7:0] v);
      for (int i = 7; i >= 0; i--) strobe(1'b1, 1'b0, v[i]);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R8: reset state
      chk("R8 reset par_data", pd1, 8'h00);
      chk("R8 reset cascade", {7'd0, cas1}, 8'h00);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      chk("R4 enabled par_oe", po1, 8'hFF);

      // R1 R2 R5: table walk through the chain
      for (int k = 0; k < 8; k++) begin
         load_byte(VEC[k]);
         chk("R5 cascade msb", {7'd0, cas1}, {7'd0, VEC[k][7]});
         strobe(1'b0, 1'b1, 1'b0);
         chk("R1 R2 first latched", pd1, VEC[k]);
         chk("R5 chained latched", pd2, (k == 0) ? 8'h00 : VEC[k-1]);
      end

      // R4 R5: outputs disabled, cascade still driven
      oe_n = 1'b1;
      @(negedge clk);
      chk("R4 disabled par_oe", po1, 8'h00);
      chk("R4 disabled par_oe chained", po2, 8'h00);
      chk("R5 cascade while disabled", {7'd0, cas1}, {7'd0, m1[7]});
      oe_n = 1'b0;
      @(negedge clk);
      chk("R4 reenabled data", pd1, h1);

      // R7: ser toggles without a strobe
      for (int i = 0; i < 20; i++) begin
         ser_in = ~ser_in;
         @(negedge clk);
      end
      strobe(1'b0, 1'b1, 1'b0);
      chk("R7 no edge no shift", pd1, m1);

      // R7: strobe held high for many cycles gives one shift
      ser_in = 1'b1;
      shift_stb = 1'b1;
      repeat (30) @(negedge clk);
      shift_stb = 1'b0;
      repeat (4) @(negedge clk);
      m2 = {m2[6:0], m1[7]};
      m1 = {m1[6:0], 1'b1};
      strobe(1'b0, 1'b1, 1'b0);
      chk("R7 long strobe single shift", pd1, m1);

      // R6: tied strobes latch pre-shift contents
      load_byte(8'hC3);
      strobe(1'b0, 1'b1, 1'b0);
      strobe(1'b1, 1'b1, 1'b0);
      chk("R6 tied pre-shift", pd1, 8'hC3);
      chk("R6 tied model", pd1, h1);
      strobe(1'b0, 1'b1, 1'b0);
      chk("R6 trailing shift visible", pd1, 8'h86);

      // R3: clear empties shift stage, leaves holding stage
      load_byte(8'hFF);
      clr_n = 1'b0;
      m1 = '0;
      @(negedge clk);
      chk("R3 clear cascade", {7'd0, cas1}, 8'h00);
      chk("R3 clear keeps hold", pd1, h1);
      strobe(1'b1, 1'b0, 1'b1);
      chk("R3 shift ignored during clear", {7'd0, cas1}, 8'h00);
      chk("R3 hold after clear shift", pd1, h1);
      clr_n = 1'b1;
      repeat (4) @(negedge clk);
      strobe(1'b0, 1'b1, 1'b0);
      chk("R3 shift stage empty", pd1, 8'h00);
      load_byte(8'h69);
      strobe(1'b0, 1'b1, 1'b0);
      chk("R3 shifting resumes", pd1, 8'h69);
      chk("R5 chained after clear", pd2, h2);

      // R8: reset mid-run
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      chk("R8 mid reset par_data", pd1, 8'h00);
      chk("R8 mid reset chained", pd2, 8'h00);
      rst_n = 1'b1;

      if (!done) begin
         done = 1'b1;
         $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
         $finish;
      end
   end

   initial begin
      #1_500_000;
      if (!done) begin
         done = 1'b1;
         n_checks++;
         n_errors++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
         $finish;
      end
   end
endmodule